// File: doc/BRIEF.md
# I2C Controller Host Register Interface

This block is the processor-side register file of a two-wire serial (I2C/SMBus) controller. A byte-wide access port reaches five registers: a data register, a combined control/status location, an own-address register, a clock setup register and a pin-pair switch register. Writes to the shared location update control and reads from it return status. While the serial output enable is off, the same read returns the low control bits so that software can test them. The serial bit engine sits outside this block. It reports events through single-cycle strobes and receives the start, stop and acknowledge requests as levels.

A small state machine tracks the pending-interrupt flag. Its states are ST_OFF (serial output disabled), ST_RUN (enabled, nothing pending) and ST_PEND (enabled, a byte has completed and waits for service). Its transitions are: any state to ST_OFF on a control write with the enable bit at 0; ST_OFF to ST_RUN on a control write with the enable bit at 1; ST_RUN to ST_PEND on a byte-complete strobe; ST_PEND to ST_RUN on a data register access or on a control write with the pending bit at 1, unless a byte-complete strobe arrives in the same cycle. The active-low interrupt output asserts in ST_PEND when the interrupt enable bit is set. A router connects the engine to one of two open-drain pin pairs and leaves the other pair released.

Top module: `i2c_host_regs`

## Requirements
- R1: After reset the control register is 0x00, the state is ST_OFF, `irq_n` is 1, every pad drive output is 0, the own-address, clock and switch registers read 0, and `bus_idle` reads 1.
- R2: Register addresses are data=0, control/status=1, own address=2, clock=3, switch=4. The own-address and clock registers read back the last byte written. The switch register keeps only bit 0 and reads its other bits as 0. Unmapped addresses read 0.
- R3: A write to address 1 updates control: bit 7 pending-clear, bit 6 serial enable, bits 5:4 reserved, bit 3 interrupt enable, bit 2 start, bit 1 stop, bit 0 acknowledge. With serial enable at 1, a read of address 1 returns status {pending_n, 0, 0, bus_error, last_bit, addressed, arb_lost, bus_idle}.
- R4: With serial enable at 0, a read of address 1 returns {4'b0, int_en, start, stop, ack}. Reserved bits 5:4 ignore writes.
- R5: With serial enable at 1, a byte-complete strobe drives pending_n to 0, loads the data register with `eng_rx_data` and loads last_bit from `eng_last_bit`. All of these are visible from the cycle after the strobe edge.
- R6: With serial enable at 1, a read or write of the data register returns pending_n to 1 from the next cycle. A write also updates `tx_data`.
- R7: With serial enable at 0, data register writes are ignored, data reads return 0x00, and engine strobes change no flag and no state.
- R8: A control write with bit 7 at 1 clears bus_error, last_bit, addressed and arb_lost, and returns pending_n to 1. bus_idle is not affected. A control write with bit 7 at 0 leaves pending_n unchanged.
- R9: An engine strobe in the same cycle as a pending-clear write wins: its flag is set, and a byte-complete strobe keeps pending_n at 0.
- R10: `irq_n` is 0 exactly when interrupt enable is 1 and pending_n is 0.
- R11: bus_idle equals the inverse of `eng_bus_busy` as sampled at the previous clock edge.
- R12: With serial enable at 1, the pair selected by the switch bit receives `eng_scl_low`/`eng_sda_low`, and `eng_scl_in`/`eng_sda_in` come from that pair's pads. The other pair's drive outputs are 0 (released). With serial enable at 0, all drive outputs are 0.
- R13: `req_start`, `req_stop` and `req_ack` equal the control bits start, stop and ack while serial enable is 1, and are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_cs | input | 1 | Access strobe, one cycle per access |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational from address |
| eng_byte_done | input | 1 | Engine strobe: byte transfer complete |
| eng_rx_data | input | 8 | Byte received by the engine |
| eng_last_bit | input | 1 | Last received bit at byte completion |
| eng_bus_err | input | 1 | Engine strobe: bus error |
| eng_arb_lost | input | 1 | Engine strobe: arbitration lost |
| eng_addressed | input | 1 | Engine strobe: addressed as target |
| eng_bus_busy | input | 1 | Level: bus currently busy |
| eng_scl_low | input | 1 | Engine request to pull clock low |
| eng_sda_low | input | 1 | Engine request to pull data low |
| eng_scl_in | output | 1 | Clock level from the selected pair |
| eng_sda_in | output | 1 | Data level from the selected pair |
| serial_en | output | 1 | Serial enable to the engine |
| req_start | output | 1 | Start request |
| req_stop | output | 1 | Stop request |
| req_ack | output | 1 | Acknowledge request |
| tx_data | output | 8 | Data register contents |
| own_addr | output | 8 | Own-address register |
| clk_cfg | output | 8 | Clock setup register |
| irq_n | output | 1 | Active-low interrupt |
| pad_scl_in | input | 2 | Clock pad levels, one per pair |
| pad_sda_in | input | 2 | Data pad levels, one per pair |
| pad_scl_low | output | 2 | Clock pad pull-low per pair |
| pad_sda_low | output | 2 | Data pad pull-low per pair |

## Verification
Register writes, engine strobes and the pending-clear take effect at the clock edge where they are presented. The status view, `irq_n`, `tx_data` and the request outputs therefore change one cycle after the stimulus. Read data and pad routing are combinational from the address, the engine inputs and the registered control state, so they are valid in the same cycle. The bench drives inputs on the falling edge and compares every output against a behavioural model shortly afterwards. Directed reads are sampled before the rising edge that applies their side effect, so a data read shows its value and only the following status read shows pending_n restored.

// File: rtl/i2c_host_pkg.sv
package i2c_host_pkg;

    localparam int REG_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
    localparam logic [ADDR_W-1:0] A_OWN  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CLK  = 3'd3;
    localparam logic [ADDR_W-1:0] A_SW   = 3'd4;

    localparam int B_PIN = 7;
    localparam int B_ESO = 6;
    localparam int B_ENI = 3;
    localparam int B_STA = 2;
    localparam int B_STO = 1;
    localparam int B_ACK = 0;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_PEND = 2'd2
    } link_state_e;

    typedef struct packed {
        logic eso;
        logic eni;
        logic sta;
        logic sto;
        logic ack;
    } ctrl_t;

    typedef struct packed {
        logic bus_err;
        logic last_bit;
        logic addressed;
        logic arb_lost;
        logic bus_idle;
    } flags_t;

endpackage

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
    import i2c_host_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic        wr_eso,
    input  logic        wr_pin,
    input  logic        data_acc,
    input  logic        byte_done,
    output link_state_e state,
    output logic        pin
);

    link_state_e state_q;
    link_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (ctrl_wr && !wr_eso) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    if (ctrl_wr) state_d = ST_RUN;
                end
                ST_RUN: begin
                    if (byte_done) state_d = ST_PEND;
                end
                ST_PEND: begin
                    if (!byte_done && (data_acc || (ctrl_wr && wr_pin))) begin
                        state_d = ST_RUN;
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        state = state_q;
        pin   = (state_q != ST_PEND);
    end

    // R5: a byte-complete in an enabled state pends unless the enable is dropped
    p_done_pends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF && byte_done && !(ctrl_wr && !wr_eso)) |=> (state_q == ST_PEND));

    // R8: writing pending bit 0 leaves a pending byte pending
    p_pin_zero_noop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && ctrl_wr && wr_eso && !wr_pin && !data_acc) |=> (state_q == ST_PEND));

    // R6: servicing the data register without a new byte returns to run
    p_service_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && data_acc && !byte_done && !ctrl_wr) |=> (state_q == ST_RUN));

endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags
    import i2c_host_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   enable,
    input  logic   clr,
    input  logic   byte_done,
    input  logic   last_bit_in,
    input  logic   bus_err,
    input  logic   arb_lost,
    input  logic   addressed,
    input  logic   bus_busy,
    output flags_t flags
);

    flags_t flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '{bus_err: 1'b0, last_bit: 1'b0, addressed: 1'b0,
                         arb_lost: 1'b0, bus_idle: 1'b1};
        end else begin
            flags_q.bus_idle <= !bus_busy;
            if (enable && bus_err)        flags_q.bus_err <= 1'b1;
            else if (clr)                 flags_q.bus_err <= 1'b0;
            if (enable && arb_lost)       flags_q.arb_lost <= 1'b1;
            else if (clr)                 flags_q.arb_lost <= 1'b0;
            if (enable && addressed)      flags_q.addressed <= 1'b1;
            else if (clr)                 flags_q.addressed <= 1'b0;
            if (enable && byte_done)      flags_q.last_bit <= last_bit_in;
            else if (clr)                 flags_q.last_bit <= 1'b0;
        end
    end

    assign flags = flags_q;

    // R8: a clear with no competing strobe empties the event flags
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(enable && (bus_err || arb_lost || addressed || byte_done)))
        |=> (!flags_q.bus_err && !flags_q.arb_lost && !flags_q.addressed && !flags_q.last_bit));

    // R9: a strobe in the clear cycle survives the clear
    p_strobe_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && enable && bus_err) |=> flags_q.bus_err);

    // R7: strobes while disabled leave the flags unchanged
    p_disabled_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !clr) |=> (flags_q.bus_err == $past(flags_q.bus_err)
                               && flags_q.arb_lost == $past(flags_q.arb_lost)));

endmodule

// File: rtl/i2c_pad_router.sv
module i2c_pad_router #(
    parameter int NUM_PAIRS = 2,
    localparam int SEL_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic [SEL_W-1:0]     sel,
    input  logic                 en,
    input  logic                 scl_low,
    input  logic                 sda_low,
    input  logic [NUM_PAIRS-1:0] pad_scl_in,
    input  logic [NUM_PAIRS-1:0] pad_sda_in,
    output logic [NUM_PAIRS-1:0] pad_scl_low,
    output logic [NUM_PAIRS-1:0] pad_sda_low,
    output logic                 scl_in,
    output logic                 sda_in
);

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
        logic hit;
        assign hit            = en && (sel == SEL_W'(k));
        assign pad_scl_low[k] = hit && scl_low;
        assign pad_sda_low[k] = hit && sda_low;
    end

    always_comb begin
        scl_in = 1'b1;
        sda_in = 1'b1;
        for (int k = 0; k < NUM_PAIRS; k++) begin
            if (sel == SEL_W'(k)) begin
                scl_in = pad_scl_in[k];
                sda_in = pad_sda_in[k];
            end
        end
    end

endmodule

// File: rtl/i2c_host_regs.sv
module i2c_host_regs
    import i2c_host_pkg::*;
#(
    parameter int NUM_PAIRS = 2,
    localparam int SEL_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_cs,
    input  logic                 cpu_we,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [REG_W-1:0]     cpu_wdata,
    output logic [REG_W-1:0]     cpu_rdata,
    input  logic                 eng_byte_done,
    input  logic [REG_W-1:0]     eng_rx_data,
    input  logic                 eng_last_bit,
    input  logic                 eng_bus_err,
    input  logic                 eng_arb_lost,
    input  logic                 eng_addressed,
    input  logic                 eng_bus_busy,
    input  logic                 eng_scl_low,
    input  logic                 eng_sda_low,
    output logic                 eng_scl_in,
    output logic                 eng_sda_in,
    output logic                 serial_en,
    output logic                 req_start,
    output logic                 req_stop,
    output logic                 req_ack,
    output logic [REG_W-1:0]     tx_data,
    output logic [REG_W-1:0]     own_addr,
    output logic [REG_W-1:0]     clk_cfg,
    output logic                 irq_n,
    input  logic [NUM_PAIRS-1:0] pad_scl_in,
    input  logic [NUM_PAIRS-1:0] pad_sda_in,
    output logic [NUM_PAIRS-1:0] pad_scl_low,
    output logic [NUM_PAIRS-1:0] pad_sda_low
);

    ctrl_t             ctrl_q;
    logic [REG_W-1:0]  data_q;
    logic [REG_W-1:0]  own_q;
    logic [REG_W-1:0]  clk_q;
    logic [SEL_W-1:0]  sw_q;

    logic wr_ctrl;
    logic data_acc;
    logic data_wr;
    logic done_g;
    logic pin_clr;
    logic pin;
    logic unused_rsv;
    link_state_e link_state;
    flags_t      flags;

    assign unused_rsv = ^cpu_wdata[5:4];

    assign wr_ctrl  = cpu_cs && cpu_we && (cpu_addr == A_CTRL);
    assign data_acc = cpu_cs && (cpu_addr == A_DATA) && ctrl_q.eso;
    assign data_wr  = data_acc && cpu_we;
    assign done_g   = eng_byte_done && ctrl_q.eso;
    assign pin_clr  = wr_ctrl && cpu_wdata[B_PIN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            data_q <= '0;
            own_q  <= '0;
            clk_q  <= '0;
            sw_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.eso <= cpu_wdata[B_ESO];
                ctrl_q.eni <= cpu_wdata[B_ENI];
                ctrl_q.sta <= cpu_wdata[B_STA];
                ctrl_q.sto <= cpu_wdata[B_STO];
                ctrl_q.ack <= cpu_wdata[B_ACK];
            end
            if (done_g)       data_q <= eng_rx_data;
            else if (data_wr) data_q <= cpu_wdata;
            if (cpu_cs && cpu_we && cpu_addr == A_OWN) own_q <= cpu_wdata;
            if (cpu_cs && cpu_we && cpu_addr == A_CLK) clk_q <= cpu_wdata;
            if (cpu_cs && cpu_we && cpu_addr == A_SW)  sw_q  <= cpu_wdata[SEL_W-1:0];
        end
    end

    i2c_link_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (wr_ctrl),
        .wr_eso    (cpu_wdata[B_ESO]),
        .wr_pin    (cpu_wdata[B_PIN]),
        .data_acc  (data_acc),
        .byte_done (done_g),
        .state     (link_state),
        .pin       (pin)
    );

    i2c_status_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (ctrl_q.eso),
        .clr         (pin_clr),
        .byte_done   (eng_byte_done),
        .last_bit_in (eng_last_bit),
        .bus_err     (eng_bus_err),
        .arb_lost    (eng_arb_lost),
        .addressed   (eng_addressed),
        .bus_busy    (eng_bus_busy),
        .flags       (flags)
    );

    i2c_pad_router #(.NUM_PAIRS(NUM_PAIRS)) u_router (
        .sel         (sw_q),
        .en          (ctrl_q.eso),
        .scl_low     (eng_scl_low),
        .sda_low     (eng_sda_low),
        .pad_scl_in  (pad_scl_in),
        .pad_sda_in  (pad_sda_in),
        .pad_scl_low (pad_scl_low),
        .pad_sda_low (pad_sda_low),
        .scl_in      (eng_scl_in),
        .sda_in      (eng_sda_in)
    );

    always_comb begin
        cpu_rdata = '0;
        case (cpu_addr)
            A_DATA: cpu_rdata = ctrl_q.eso ? data_q : '0;
            A_CTRL: begin
                if (ctrl_q.eso) begin
                    cpu_rdata = {pin, 2'b00, flags.bus_err, flags.last_bit,
                                 flags.addressed, flags.arb_lost, flags.bus_idle};
                end else begin
                    cpu_rdata = {4'b0000, ctrl_q.eni, ctrl_q.sta, ctrl_q.sto, ctrl_q.ack};
                end
            end
            A_OWN:   cpu_rdata = own_q;
            A_CLK:   cpu_rdata = clk_q;
            A_SW:    cpu_rdata = REG_W'(sw_q);
            default: cpu_rdata = '0;
        endcase
    end

    assign serial_en = ctrl_q.eso;
    assign req_start = ctrl_q.eso && ctrl_q.sta;
    assign req_stop  = ctrl_q.eso && ctrl_q.sto;
    assign req_ack   = ctrl_q.eso && ctrl_q.ack;
    assign tx_data   = data_q;
    assign own_addr  = own_q;
    assign clk_cfg   = clk_q;
    assign irq_n     = !(ctrl_q.eni && !pin);

    // R7: data writes while disabled leave the data register unchanged
    p_data_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_cs && cpu_we && cpu_addr == A_DATA && !ctrl_q.eso && !wr_ctrl) |=> $stable(data_q));

    // R10: a serviced pending byte releases the interrupt on the next cycle
    p_irq_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == ST_PEND && data_acc && !eng_byte_done) |=> irq_n);

    // R12: the enable state and the pad drives agree
    p_pads_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (link_state == ST_OFF) |-> (pad_scl_low == '0 && pad_sda_low == '0));

endmodule

// File: tb/i2c_host_regs_tb.sv
module i2c_host_regs_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_cs = 1'b0, cpu_we = 1'b0;
    logic [2:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       eng_byte_done = 1'b0;
    logic [7:0] eng_rx_data = '0;
    logic       eng_last_bit = 1'b0, eng_bus_err = 1'b0, eng_arb_lost = 1'b0;
    logic       eng_addressed = 1'b0, eng_bus_busy = 1'b0;
    logic       eng_scl_low = 1'b0, eng_sda_low = 1'b0;
    logic       eng_scl_in, eng_sda_in, serial_en, req_start, req_stop, req_ack, irq_n;
    logic [7:0] tx_data, own_addr, clk_cfg;
    logic [1:0] pad_scl_in = 2'b11, pad_sda_in = 2'b11;
    logic [1:0] pad_scl_low, pad_sda_low;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    i2c_host_regs u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_cs(cpu_cs), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .eng_byte_done(eng_byte_done),
        .eng_rx_data(eng_rx_data), .eng_last_bit(eng_last_bit), .eng_bus_err(eng_bus_err),
        .eng_arb_lost(eng_arb_lost), .eng_addressed(eng_addressed), .eng_bus_busy(eng_bus_busy),
        .eng_scl_low(eng_scl_low), .eng_sda_low(eng_sda_low), .eng_scl_in(eng_scl_in),
        .eng_sda_in(eng_sda_in), .serial_en(serial_en), .req_start(req_start),
        .req_stop(req_stop), .req_ack(req_ack), .tx_data(tx_data), .own_addr(own_addr),
        .clk_cfg(clk_cfg), .irq_n(irq_n), .pad_scl_in(pad_scl_in), .pad_sda_in(pad_sda_in),
        .pad_scl_low(pad_scl_low), .pad_sda_low(pad_sda_low)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    bit m_eso, m_eni, m_sta, m_sto, m_ack, m_pin;
    bit m_err, m_last, m_adr, m_arb, m_idle;
    bit [7:0] m_data, m_own, m_clk;
    bit m_sw;

    task automatic model_reset();
        {m_eso, m_eni, m_sta, m_sto, m_ack} = '0;
        m_pin = 1; m_err = 0; m_last = 0; m_adr = 0; m_arb = 0; m_idle = 1;
        m_data = 0; m_own = 0; m_clk = 0; m_sw = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit cw, clr, done, dacc;
            cw   = cpu_cs && cpu_we && cpu_addr == 3'd1;
            clr  = cw && cpu_wdata[7];
            done = eng_byte_done && m_eso;
            dacc = cpu_cs && cpu_addr == 3'd0 && m_eso;
            if (clr) begin m_err = 0; m_last = 0; m_adr = 0; m_arb = 0; end
            if (m_eso) begin
                if (eng_bus_err)   m_err = 1;
                if (eng_arb_lost)  m_arb = 1;
                if (eng_addressed) m_adr = 1;
                if (eng_byte_done) m_last = eng_last_bit;
            end
            m_idle = !eng_bus_busy;
            if (cw && !cpu_wdata[6]) m_pin = 1;
            else if (done)           m_pin = 0;
            else if (dacc || clr)    m_pin = 1;
            if (done) m_data = eng_rx_data;
            else if (dacc && cpu_we) m_data = cpu_wdata;
            if (cpu_cs && cpu_we && cpu_addr == 3'd2) m_own = cpu_wdata;
            if (cpu_cs && cpu_we && cpu_addr == 3'd3) m_clk = cpu_wdata;
            if (cpu_cs && cpu_we && cpu_addr == 3'd4) m_sw = cpu_wdata[0];
            if (cw) begin
                m_eso = cpu_wdata[6]; m_eni = cpu_wdata[3]; m_sta = cpu_wdata[2];
                m_sto = cpu_wdata[1]; m_ack = cpu_wdata[0];
            end
        end
    end

    function automatic bit [7:0] exp_rdata(input bit [2:0] a);
        case (a)
            3'd0: return m_eso ? m_data : 8'h00;
            3'd1: return m_eso ? {m_pin, 2'b00, m_err, m_last, m_adr, m_arb, m_idle}
                               : {4'b0000, m_eni, m_sta, m_sto, m_ack};
            3'd2: return m_own;
            3'd3: return m_clk;
            3'd4: return {7'b0, m_sw};
            default: return 8'h00;
        endcase
    endfunction

    task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp, inout bit bad);
        if (act !== exp) begin
            bad = 1;
            $display("FAIL %s model compare at cycle %0d: actual %h expected %h", tag, cycles, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            bit bad;
            bad = 0;
            tests++;
            cmp("R2/R3/R4", cpu_rdata, exp_rdata(cpu_addr), bad);
            cmp("R10", {7'b0, irq_n}, {7'b0, !(m_eni && !m_pin)}, bad);
            cmp("R6", tx_data, m_data, bad);
            cmp("R13", {5'b0, req_start, req_stop, req_ack},
                {5'b0, m_eso && m_sta, m_eso && m_sto, m_eso && m_ack}, bad);
            cmp("R12", {4'b0, pad_scl_low, pad_sda_low},
                {4'b0, (m_eso && m_sw) && eng_scl_low, (m_eso && !m_sw) && eng_scl_low,
                       (m_eso && m_sw) && eng_sda_low, (m_eso && !m_sw) && eng_sda_low}, bad);
            cmp("R12", {6'b0, eng_scl_in, eng_sda_in},
                {6'b0, pad_scl_in[m_sw], pad_sda_in[m_sw]}, bad);
            cmp("R2", own_addr, m_own, bad);
            cmp("R2", clk_cfg, m_clk, bad);
            cmp("R3", {7'b0, serial_en}, {7'b0, m_eso}, bad);
            if (bad) fails++;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit [2:0] a, input bit [7:0] d);
        @(negedge clk);
        cpu_cs = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_cs = 0; cpu_we = 0;
    endtask

    task automatic rd(input bit [2:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_cs = 1; cpu_we = 0; cpu_addr = a;
        #2 d = cpu_rdata;
        @(negedge clk);
        cpu_cs = 0;
    endtask

    task automatic pulse_done(input bit [7:0] rx, input bit lb);
        @(negedge clk);
        eng_byte_done = 1; eng_rx_data = rx; eng_last_bit = lb;
        @(negedge clk);
        eng_byte_done = 0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        rd(3'd1, v); chk("R1 control after reset", v, 8'h00);
        chk("R1 irq_n after reset", {7'b0, irq_n}, 8'h01);
        chk("R1 pads released after reset", {4'b0, pad_scl_low, pad_sda_low}, 8'h00);
        rd(3'd4, v); chk("R1 switch after reset", v, 8'h00);
        // R2: setup registers and map
        wr(3'd2, 8'h5A); wr(3'd3, 8'h1C); wr(3'd4, 8'hFF);
        rd(3'd2, v); chk("R2 own address", v, 8'h5A);
        rd(3'd3, v); chk("R2 clock register", v, 8'h1C);
        rd(3'd4, v); chk("R2 switch keeps bit 0", v, 8'h01);
        rd(3'd6, v); chk("R2 unmapped reads 0", v, 8'h00);
        // R4: disabled view, reserved bits ignored
        wr(3'd1, 8'h3F);
        rd(3'd1, v); chk("R4 test view of control", v, 8'h0F);
        chk("R13 requests held off while disabled", {5'b0, req_start, req_stop, req_ack}, 8'h00);
        // R7: disabled data path and strobes
        wr(3'd0, 8'h33);
        chk("R7 tx_data unchanged", tx_data, 8'h00);
        rd(3'd0, v); chk("R7 data read while disabled", v, 8'h00);
        pulse_done(8'hEE, 1);
        chk("R7 strobe ignored, irq_n", {7'b0, irq_n}, 8'h01);
        // R3: enable, status view
        eng_bus_busy = 0; eng_scl_low = 1; eng_sda_low = 0;
        wr(3'd1, 8'h48);
        rd(3'd1, v); chk("R3 status view after enable", v, 8'h81);
        chk("R12 pair 1 driven, pair 0 released", {4'b0, pad_scl_low, pad_sda_low}, 8'h08);
        // R5: byte done
        pulse_done(8'hA5, 1);
        rd(3'd1, v); chk("R5 pending status", v, 8'h09);
        chk("R10 irq_n asserted", {7'b0, irq_n}, 8'h00);
        rd(3'd0, v); chk("R5 received byte", v, 8'hA5);
        // R6: data read restores pending_n
        rd(3'd1, v); chk("R6 pending cleared by data read", v, 8'h89);
        chk("R10 irq_n released", {7'b0, irq_n}, 8'h01);
        // R11 and event flags
        @(negedge clk); eng_bus_err = 1; eng_arb_lost = 1; eng_addressed = 1; eng_bus_busy = 1;
        @(negedge clk); eng_bus_err = 0; eng_arb_lost = 0; eng_addressed = 0;
        rd(3'd1, v); chk("R11 busy and event flags", v, 8'h9E);
        // R8: pending-clear keeps bus_idle
        wr(3'd1, 8'hC8);
        rd(3'd1, v); chk("R8 clear keeps bus_idle", v, 8'h80);
        pulse_done(8'h11, 0);
        wr(3'd1, 8'h48);
        rd(3'd1, v); chk("R8 pending bit 0 has no effect", v, 8'h00);
        // R9: strobe in the clear cycle wins
        @(negedge clk);
        cpu_cs = 1; cpu_we = 1; cpu_addr = 3'd1; cpu_wdata = 8'hC8; eng_bus_err = 1;
        @(negedge clk);
        cpu_cs = 0; cpu_we = 0; eng_bus_err = 0;
        rd(3'd1, v); chk("R9 strobe wins over clear", v, 8'h90);
        @(negedge clk);
        cpu_cs = 1; cpu_we = 1; cpu_addr = 3'd1; cpu_wdata = 8'hC8; eng_byte_done = 1;
        @(negedge clk);
        cpu_cs = 0; cpu_we = 0; eng_byte_done = 0;
        chk("R9 byte-complete wins, irq_n low", {7'b0, irq_n}, 8'h00);
        // R6 and R13
        wr(3'd0, 8'h77);
        chk("R6 tx_data written", tx_data, 8'h77);
        chk("R10 irq_n released by data write", {7'b0, irq_n}, 8'h01);
        wr(3'd1, 8'h4E);
        chk("R13 requests", {5'b0, req_start, req_stop, req_ack}, 8'h06);
        // R12: switch to pair 0
        wr(3'd4, 8'h00);
        eng_sda_low = 1; pad_scl_in = 2'b10; pad_sda_in = 2'b01;
        #2;
        chk("R12 pair 0 driven", {4'b0, pad_scl_low, pad_sda_low}, 8'h05);
        chk("R12 inputs from pair 0", {6'b0, eng_scl_in, eng_sda_in}, 8'h01);
        wr(3'd1, 8'h00);
        chk("R12 all released when disabled", {4'b0, pad_scl_low, pad_sda_low}, 8'h00);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule